// File: doc/BRIEF.md
# Line-Locked PLL Feedback Divider and Detector Control

This block holds the digital half of a PLL that locks to the horizontal line rate. It runs entirely on the VCO clock. A programmable counter divides that clock by a 12-bit ratio to produce the feedback clock. The asynchronous reference, sync and coast inputs are brought into the clock domain. A two-flop phase-frequency detector compares the selected reference edge with each feedback wrap and requests charge-pump up or down current. The pump, loop filter and oscillator are analog and lie outside the block.

Settings arrive as byte writes on a plain write strobe, address and data. None of the ports is a stream, so there is no valid/ready pairing and nothing at the block edge can be back-pressured. Every write is taken on the clock edge at which the strobe is high.

A new divide ratio goes in two steps. First the top bits and the parity bit are staged. The write of the middle byte then commits the whole ratio. Address 0 comes before address 1, so an ascending burst that changes the top or parity bits needs a second pass before the new ratio appears. The detector can be set to respond to either reference edge. Both the coast input and the sync input can be inverted. Two test bits force the pump requests.

Top module: `llpll_ctrl`

## Requirements
- R1: After reset the divide ratio is 800 and every control bit is 0. `pump_up` and `pump_dn` are low, and `fb_clk` has a period of 800 clock cycles.
- R2: A write to address 1 only stages the upper ratio bits and the parity bit: data[3:1] becomes ratio[11:9] and data[0] becomes ratio[0]. The feedback period does not change.
- R3: A write to address 0 commits the ratio as {staged top bits, data[7:0] as ratio[8:1], staged parity bit}. Later feedback periods use the new ratio.
- R4: An ascending write of address 0 then address 1 that changes the parity bit leaves the old parity in effect. A second write of address 0 applies the new one.
- R5: `fb_clk` repeats every N cycles. It is high for floor(N/2) cycles, starting in the cycle after the counter wraps. A ratio below 2 behaves as 2.
- R6: A selected reference edge raises `pump_up` 3 clock edges after the input changes. A feedback wrap raises `pump_dn`.
- R7: When both requests are set they are high together for exactly one cycle. Both are then cleared.
- R8: Control register (address 2) bit 0 selects the reference edge: 0 selects the rising edge and 1 the falling edge. The other edge has no effect on `pump_up`.
- R9: While coast is active both pump requests stay low and the detector state is cleared.
- R10: Control bit 1 inverts the coast input and bit 2 inverts the sync input. `line_sync` is the active-high sync, 2 cycles after the pin changes.
- R11: Control bit 3 forces `pump_up` high and bit 4 forces `pump_dn` high, even during coast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_in | input | 1 | Line-rate reference, asynchronous |
| hsync_in | input | 1 | Horizontal sync, asynchronous |
| coast_in | input | 1 | Coast request, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = ratio middle byte, 1 = top/parity, 2 = control |
| wr_data | input | 8 | Write data |
| fb_clk | output | 1 | Divided feedback clock |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| line_sync | output | 1 | Synchronized, active-high sync |

## Verification
The reference-edge event and the feedback wrap both act on the detector in the same cycle whenever the up request lands while the down request is still held. The bench provokes this collision by waiting until `pump_dn` is high from a wrap and then driving the selected reference edge. It judges the result by requiring exactly one cycle with both requests high, followed by a cycle with both low. The second case is a ratio commit that arrives while the counter is already above the new terminal value. This is judged by measuring whole feedback periods after the commit.

// File: rtl/llpll_pkg.sv
package llpll_pkg;
  localparam int RATIO_W = 12;
  localparam logic [RATIO_W-1:0] DEF_RATIO = 12'd800;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_MID = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TOP = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = 2'd2;

  typedef struct packed {
    logic force_dn;
    logic force_up;
    logic hsync_inv;
    logic coast_inv;
    logic edge_fall;
  } llpll_ctl_t;

  localparam int CTL_W = $bits(llpll_ctl_t);
endpackage

// File: rtl/llpll_sync.sv
module llpll_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/llpll_regs.sv
module llpll_regs
  import llpll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [RATIO_W-1:0] ratio,
  output llpll_ctl_t         ctl
);
  localparam int TOP_W = RATIO_W - DATA_W - 1;

  logic [TOP_W-1:0] top_stage;
  logic             par_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_stage <= DEF_RATIO[RATIO_W-1 -: TOP_W];
      par_stage <= DEF_RATIO[0];
      ratio     <= DEF_RATIO;
      ctl       <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_TOP: begin
          top_stage <= wr_data[TOP_W:1];
          par_stage <= wr_data[0];
        end
        ADDR_MID: ratio <= {top_stage, wr_data, par_stage};
        ADDR_CTL: ctl   <= wr_data[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  AST_TOP_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_TOP) |=> $stable(ratio))
    else $error("staging write changed ratio"); // R2
endmodule

// File: rtl/llpll_fbdiv.sv
module llpll_fbdiv
  import llpll_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               fb_clk,
  output logic               fb_evt
);
  logic [RATIO_W-1:0] eff_n;
  logic [RATIO_W-1:0] cnt;

  assign eff_n  = (ratio < RATIO_W'(2)) ? RATIO_W'(2) : ratio;
  assign fb_evt = (cnt >= eff_n - RATIO_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (fb_evt) cnt <= '0;
    else             cnt <= cnt + RATIO_W'(1);
  end

  assign fb_clk = (cnt < (eff_n >> 1));

  AST_FB_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_clk) |-> (cnt == '0))
    else $error("feedback rose away from wrap"); // R5
endmodule

// File: rtl/llpll_pfd.sv
module llpll_pfd
  import llpll_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic       hsync_in,
  input  logic       coast_in,
  input  llpll_ctl_t ctl,
  input  logic       fb_evt,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       line_sync
);
  logic [2:0] raw_s;
  logic       ref_s, ref_p, ref_evt, coast_act;
  logic       up_q, dn_q, both;

  llpll_sync #(.WIDTH(3), .STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({coast_in, hsync_in, ref_in}),
    .q    (raw_s)
  );

  assign ref_s     = raw_s[0];
  assign line_sync = raw_s[1] ^ ctl.hsync_inv;
  assign coast_act = raw_s[2] ^ ctl.coast_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_p <= 1'b0;
    else        ref_p <= ref_s;
  end

  assign ref_evt = ctl.edge_fall ? (ref_p & ~ref_s) : (ref_s & ~ref_p);
  assign both    = up_q & dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else if (coast_act || both) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_q | ref_evt;
      dn_q <= dn_q | fb_evt;
    end
  end

  assign pump_up = up_q | ctl.force_up;
  assign pump_dn = dn_q | ctl.force_dn;

  AST_BOTH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q))
    else $error("detector reset held"); // R7
  AST_COAST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    coast_act |=> (!up_q && !dn_q))
    else $error("detector active in coast"); // R9
  AST_REF_SETS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_evt && !coast_act && !both) |=> up_q)
    else $error("reference edge lost"); // R6
endmodule

// File: rtl/llpll_ctrl.sv
module llpll_ctrl
  import llpll_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              hsync_in,
  input  logic              coast_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fb_clk,
  output logic              pump_up,
  output logic              pump_dn,
  output logic              line_sync
);
  logic [RATIO_W-1:0] ratio;
  llpll_ctl_t         ctl;
  logic               fb_evt;

  llpll_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .ratio  (ratio),
    .ctl    (ctl)
  );

  llpll_fbdiv u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .ratio (ratio),
    .fb_clk(fb_clk),
    .fb_evt(fb_evt)
  );

  llpll_pfd u_pfd (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .hsync_in (hsync_in),
    .coast_in (coast_in),
    .ctl      (ctl),
    .fb_evt   (fb_evt),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .line_sync(line_sync)
  );
endmodule

// File: tb/sim_llpll_ctrl.sv
module sim_llpll_ctrl;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, hsync_in = 1'b0, coast_in = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic fb_clk, pump_up, pump_dn, line_sync;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  llpll_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .hsync_in(hsync_in),
    .coast_in(coast_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fb_clk(fb_clk), .pump_up(pump_up), .pump_dn(pump_dn), .line_sync(line_sync)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_rise(output int cyc);
    logic prev;
    bit seen;
    cyc = 0; seen = 1'b0;
    prev = fb_clk;
    while (!seen && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (fb_clk && !prev) seen = 1'b1;
      prev = fb_clk;
    end
  endtask

  task automatic period(output int p);
    int x;
    wait_rise(x);
    wait_rise(x);
    wait_rise(p);
  endtask

  task automatic wait_dn();
    for (int i = 0; i < 200 && !pump_dn; i++) @(negedge clk);
  endtask

  // drive ref to lvl, look for the one-cycle both-high window, then both low
  task automatic edge_expect_pair(input logic lvl, input string req);
    int hit;
    hit = 0;
    wait_dn();
    @(negedge clk) ref_in = lvl;
    for (int i = 0; i < 6 && hit == 0; i++) begin
      @(negedge clk);
      if (pump_up && pump_dn) hit = 1;
    end
    chk({req, " up and down together"}, hit, 1);
    @(negedge clk);
    chk({req, " both cleared after one cycle (R7)"}, int'(pump_up || pump_dn), 0);
  endtask

  task automatic edge_expect_none(input logic lvl, input string req);
    int seen;
    seen = 0;
    @(negedge clk) ref_in = lvl;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (pump_up) seen = 1;
    end
    chk({req, " unselected edge no up"}, seen, 0);
  endtask

  task automatic t_reset();
    int p;
    chk("R1 pump_up reset", int'(pump_up), 0);
    chk("R1 pump_dn reset", int'(pump_dn), 0);
    chk("R1 line_sync reset", int'(line_sync), 0);
    period(p);
    chk("R1 default period", p, 800);
  endtask

  task automatic t_stage_commit();
    int p;
    wr(2'd1, 8'h01);               // top 0, parity 1
    period(p);
    chk("R2 staged only", p, 800);
    wr(2'd0, 8'd18);               // {0,18,1} = 37
    period(p);
    chk("R3 committed ratio", p, 37);
  endtask

  task automatic t_burst_order();
    int p;
    wr(2'd0, 8'd25);               // old parity 1 -> 51
    period(p);
    chk("R4 first pass old parity", p, 51);
    wr(2'd1, 8'h00);
    period(p);
    chk("R4 parity staged only", p, 51);
    wr(2'd0, 8'd25);               // {0,25,0} = 50
    period(p);
    chk("R4 second pass applies", p, 50);
  endtask

  task automatic t_small_ratio();
    int p;
    int hi;
    wr(2'd0, 8'd0);                // ratio 0 acts as 2
    period(p);
    chk("R5 ratio below 2 period", p, 2);
    wr(2'd0, 8'd3);                // {0,3,0} = 6
    period(p);
    chk("R5 ratio 6 period", p, 6);
    hi = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (fb_clk) hi++;
    end
    chk("R5 high time floor(N/2)", hi, 3);
    wr(2'd0, 8'd25);               // back to 50
  endtask

  task automatic t_edges();
    edge_expect_pair(1'b1, "R6 R8 rising selected");
    edge_expect_none(1'b0, "R8 falling with select 0");
    wr(2'd2, 8'h01);
    edge_expect_none(1'b1, "R8 rising with select 1");
    edge_expect_pair(1'b0, "R6 R8 falling selected");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_coast_pol();
    int seen;
    coast_in = 1'b1;
    repeat (4) @(negedge clk);
    seen = 0;
    ref_in = 1'b1;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (pump_up || pump_dn) seen = 1;
    end
    chk("R9 coast holds pumps low", seen, 0);
    ref_in = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h02);               // coast inverted: pin high = inactive
    edge_expect_pair(1'b1, "R10 coast inverted");
    @(negedge clk) hsync_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 sync direct", int'(line_sync), 1);
    wr(2'd2, 8'h06);
    chk("R10 sync inverted", int'(line_sync), 0);
  endtask

  task automatic t_force();
    wr(2'd2, 8'h08);               // coast pin high, polarity 0 -> coast active
    chk("R11 force up", int'(pump_up), 1);
    chk("R11 force up leaves dn", int'(pump_dn), 0);
    wr(2'd2, 8'h10);
    chk("R11 force dn", int'(pump_dn), 1);
    chk("R11 force dn leaves up", int'(pump_up), 0);
    wr(2'd2, 8'h00);
    chk("R11 release", int'(pump_up || pump_dn), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_commit();
    t_burst_order();
    t_small_ratio();
    t_edges();
    t_coast_pol();
    t_force();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule